// File: doc/BRIEF.md
# UART Handshake Flow Controller

This block adds automatic hardware flow control to a UART. It tells the remote end when the local receiver is nearly full: the count of bytes in the receive FIFO is compared against a programmable watermark, and the block drives an active-low request output from that comparison. It also gates the local transmitter from the remote end's active-low clear input. That input is first passed through a two-stage synchronizer. A transmit request is granted only at a character boundary, when the transmitter asks to start its next character. A character already being shifted out is never cut short.

A two-bit mode selects the handshake pair. The pair is either request/clear-to-send or terminal-ready/set-ready. Mode can also switch flow control off. In that case both output pins follow software data bits like plain GPIO, the transmitter is always permitted, and both handshake inputs are ignored. The output of the unselected pair also follows its data bit. A watermark value of zero selects a built-in default of 450 bytes.

Top module: `hsfc_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, both `rts_n` and `dtr_n` are high.
- R2: With `mode` = 2'b01 (RTS/CTS pair), `rts_n` is low one cycle after a cycle in which `fifo_count` is below the effective watermark.
- R3: With `mode` = 2'b01, `rts_n` is high one cycle after a cycle in which `fifo_count` is equal to or above the effective watermark.
- R4: The effective watermark is `watermark`, except that a `watermark` of 0 selects the default of 450.
- R5: In a flow-control mode, `tx_permit` equals the inverse of the selected handshake input as sampled two clock edges earlier: a high input suspends permission and a low input restores it.
- R6: With `mode` = 2'b10 (DTR/DSR pair), `dtr_n` follows the watermark comparison with the same timing as R2 and R3, and `dsr_n` gates `tx_permit`. In either flow-control mode, the output of the unselected pair follows its GPIO bit one cycle later, and the unselected input has no effect on `tx_permit`.
- R7: With `mode` = 2'b00 or 2'b11 (flow control off), `tx_permit` is 1 whatever `cts_n` and `dsr_n` are. In that mode `rts_n` and `dtr_n` equal `gpio_rts` and `gpio_dtr` one cycle later.
- R8: `tx_go` is high in exactly the cycles where `tx_start_req` and `tx_permit` are both high. A request that meets a suspended permit is not granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 00/11 off, 01 RTS/CTS pair, 10 DTR/DSR pair |
| fifo_count | input | CNT_W | Bytes held in the receive FIFO |
| watermark | input | CNT_W | Deassert level; 0 selects DEFAULT_WM |
| gpio_rts | input | 1 | Data bit driven on rts_n when that pin is not doing flow control |
| gpio_dtr | input | 1 | Data bit driven on dtr_n when that pin is not doing flow control |
| cts_n | input | 1 | Remote clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Remote set-ready, active low, asynchronous |
| tx_start_req | input | 1 | Transmitter asks to begin its next character |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| tx_permit | output | 1 | Transmitter may start a character |
| tx_go | output | 1 | Start request granted this cycle |

## Verification
A start-of-character request can land in the very cycle that the synchronized remote input withdraws permission. The bench holds `tx_start_req` high and raises the selected handshake input, then checks `tx_go` each cycle. `tx_go` must stay high for the one cycle before the synchronizer output changes. It must fall in exactly the second cycle, and no request may be granted after that. The watermark comparison is swept over every FIFO count against several watermarks in every mode, while the GPIO bits change under it. This confirms that a crossing on one pin never disturbs the other pin.

// File: rtl/hsfc_pkg.sv
package hsfc_pkg;
    typedef enum logic [1:0] {
        FC_OFF     = 2'b00,
        FC_RTSCTS  = 2'b01,
        FC_DTRDSR  = 2'b10,
        FC_OFF_ALT = 2'b11
    } fc_mode_e;
endpackage

// File: rtl/hsfc_sync.sv
module hsfc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.stg[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.stg[i] = sync_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.stg[STAGES-1];
endmodule

// File: rtl/hsfc_level.sv
module hsfc_level
    import hsfc_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int DEFAULT_WM = 450
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fc_mode_e         mode,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] watermark,
    input  logic             gpio_rts,
    input  logic             gpio_dtr,
    output logic             rts_n,
    output logic             dtr_n
);
    localparam logic [CNT_W-1:0] DEF_WM_V = CNT_W'(DEFAULT_WM);

    typedef struct packed {
        logic rts_n;
        logic dtr_n;
    } lvl_t;

    lvl_t             lvl_d, lvl_q;
    logic [CNT_W-1:0] eff_wm;
    logic             at_mark;

    always_comb begin
        eff_wm  = (watermark == '0) ? DEF_WM_V : watermark;
        at_mark = (fifo_count >= eff_wm);
        lvl_d.rts_n = gpio_rts;
        lvl_d.dtr_n = gpio_dtr;
        case (mode)
            FC_RTSCTS: lvl_d.rts_n = at_mark;
            FC_DTRDSR: lvl_d.dtr_n = at_mark;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '1;
        else        lvl_q <= lvl_d;
    end

    assign rts_n = lvl_q.rts_n;
    assign dtr_n = lvl_q.dtr_n;

    p_mark_rts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == FC_RTSCTS)
        |-> (rts_n == ($past(fifo_count) >= $past(eff_wm))));

    p_mark_dtr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == FC_DTRDSR)
        |-> (dtr_n == ($past(fifo_count) >= $past(eff_wm))));

    p_gpio_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode) == FC_OFF || $past(mode) == FC_OFF_ALT))
        |-> (rts_n == $past(gpio_rts) && dtr_n == $past(gpio_dtr)));

    p_reset_high_r1: assert property (@(posedge clk)
        !rst_n |=> (rts_n && dtr_n));
endmodule

// File: rtl/hsfc_gate.sv
module hsfc_gate
    import hsfc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  fc_mode_e mode,
    input  logic     cts_s_n,
    input  logic     dsr_s_n,
    input  logic     tx_start_req,
    output logic     tx_permit,
    output logic     tx_go
);
    always_comb begin
        case (mode)
            FC_RTSCTS: tx_permit = !cts_s_n;
            FC_DTRDSR: tx_permit = !dsr_s_n;
            default:   tx_permit = 1'b1;
        endcase
        tx_go = tx_start_req && tx_permit;
    end

    p_off_permit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FC_OFF || mode == FC_OFF_ALT) |-> (tx_go == tx_start_req));

    p_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> (tx_start_req && tx_permit));
endmodule

// File: rtl/hsfc_top.sv
module hsfc_top
    import hsfc_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int DEFAULT_WM  = 450,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] watermark,
    input  logic             gpio_rts,
    input  logic             gpio_dtr,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             tx_start_req,
    output logic             rts_n,
    output logic             dtr_n,
    output logic             tx_permit,
    output logic             tx_go
);
    localparam int HS_W = 2;

    fc_mode_e        mode_e;
    logic [HS_W-1:0] hs_sync;

    assign mode_e = fc_mode_e'(mode);

    hsfc_sync #(.WIDTH(HS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dsr_n, cts_n}),
        .sync_out (hs_sync)
    );

    hsfc_level #(.CNT_W(CNT_W), .DEFAULT_WM(DEFAULT_WM)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_e),
        .fifo_count (fifo_count),
        .watermark  (watermark),
        .gpio_rts   (gpio_rts),
        .gpio_dtr   (gpio_dtr),
        .rts_n      (rts_n),
        .dtr_n      (dtr_n)
    );

    hsfc_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode_e),
        .cts_s_n      (hs_sync[0]),
        .dsr_s_n      (hs_sync[1]),
        .tx_start_req (tx_start_req),
        .tx_permit    (tx_permit),
        .tx_go        (tx_go)
    );

    generate
        if (SYNC_STAGES == 2) begin : g_sync_chk
            p_cts_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2) && mode_e == FC_RTSCTS)
                |-> (tx_permit == !$past(cts_n, 2)));
            p_dsr_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2) && mode_e == FC_DTRDSR)
                |-> (tx_permit == !$past(dsr_n, 2)));
        end
    endgenerate
endmodule

// File: tb/hsfc_top_bench.sv
module hsfc_top_bench;
    localparam int CNT_W = 10;
    localparam int DEF   = 450;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [CNT_W-1:0] fifo_count = '0;
    logic [CNT_W-1:0] watermark = '0;
    logic             gpio_rts = 1'b0;
    logic             gpio_dtr = 1'b0;
    logic             cts_n = 1'b0;
    logic             dsr_n = 1'b0;
    logic             tx_start_req = 1'b0;
    logic             rts_n, dtr_n, tx_permit, tx_go;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    hsfc_top #(.CNT_W(CNT_W), .DEFAULT_WM(DEF)) u_hsfc_top (
        .clk(clk), .rst_n(rst_n), .mode(mode), .fifo_count(fifo_count),
        .watermark(watermark), .gpio_rts(gpio_rts), .gpio_dtr(gpio_dtr),
        .cts_n(cts_n), .dsr_n(dsr_n), .tx_start_req(tx_start_req),
        .rts_n(rts_n), .dtr_n(dtr_n), .tx_permit(tx_permit), .tx_go(tx_go)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        int wms[6] = '{0, 1, 7, 450, 512, 1023};
        // R1: reset state
        mode = 2'b01;
        fifo_count = 10'd5;
        repeat (3) step();
        chk("R1 rts_n in reset", rts_n, 1'b1);
        chk("R1 dtr_n in reset", dtr_n, 1'b1);
        rst_n = 1'b1;
        step();
        chk("R1 rts_n after release", rts_n, 1'b0);
        chk("R1 dtr_n after release", dtr_n, 1'b0);
        step();
        step();

        // R2 R3 R4 R6 R7: sweep of all counts against several watermarks in all modes
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 6; w++) begin
                for (int c = 0; c < 1024; c++) begin
                    int  eff;
                    logic full, er, ed;
                    mode       = m[1:0];
                    watermark  = wms[w][CNT_W-1:0];
                    fifo_count = c[CNT_W-1:0];
                    gpio_rts   = c[0];
                    gpio_dtr   = ~c[1];
                    eff  = (wms[w] == 0) ? DEF : wms[w];
                    full = (c >= eff);
                    er = gpio_rts;
                    ed = gpio_dtr;
                    if (m == 1) er = full;
                    if (m == 2) ed = full;
                    step();
                    if (m == 1) chk(full ? "R3 rts_n at/above mark" : "R2 rts_n below mark", rts_n, er);
                    else if (m == 2) chk("R6 dtr_n mark", dtr_n, ed);
                    else chk("R7 rts_n gpio", rts_n, er);
                    if (m == 1) chk("R6 unselected dtr_n gpio", dtr_n, ed);
                    else if (m == 2) chk("R6 unselected rts_n gpio", rts_n, er);
                    else chk("R7 dtr_n gpio", dtr_n, ed);
                    if (w == 0 && (c == 449 || c == 450)) chk("R4 default mark", full ? 1'b1 : 1'b0, (c >= 450) ? 1'b1 : 1'b0);
                end
            end
        end

        // R5 R8: suspend collides with a pending start request, RTS/CTS pair
        mode = 2'b01; cts_n = 1'b0; dsr_n = 1'b0; tx_start_req = 1'b1;
        step(); step();
        chk("R5 permit with cts low", tx_permit, 1'b1);
        chk("R8 go granted", tx_go, 1'b1);
        cts_n = 1'b1;
        step();
        chk("R5 permit one edge after cts high", tx_permit, 1'b1);
        chk("R8 go before sync output changes", tx_go, 1'b1);
        step();
        chk("R5 suspended two edges after cts high", tx_permit, 1'b0);
        chk("R8 request not granted while suspended", tx_go, 1'b0);
        dsr_n = 1'b1;
        step(); step();
        chk("R6 unselected dsr_n ignored", tx_permit, 1'b0);
        dsr_n = 1'b0;
        cts_n = 1'b0;
        step();
        chk("R5 still suspended one edge after cts low", tx_permit, 1'b0);
        step();
        chk("R5 resumed two edges after cts low", tx_permit, 1'b1);
        chk("R8 go resumes", tx_go, 1'b1);
        tx_start_req = 1'b0;
        step();
        chk("R8 no request no go", tx_go, 1'b0);

        // R6: DTR/DSR pair gates the transmitter
        mode = 2'b10; tx_start_req = 1'b1;
        cts_n = 1'b1;
        step(); step();
        chk("R6 cts_n ignored in dtr mode", tx_permit, 1'b1);
        dsr_n = 1'b1;
        step();
        chk("R6 permit one edge after dsr high", tx_permit, 1'b1);
        step();
        chk("R6 suspended by dsr_n", tx_permit, 1'b0);
        chk("R8 go blocked by dsr_n", tx_go, 1'b0);

        // R7: flow control off ignores both inputs
        for (int m = 0; m < 4; m += 3) begin
            mode = m[1:0];
            cts_n = 1'b1; dsr_n = 1'b1;
            step(); step(); step();
            chk("R7 permit with flow control off", tx_permit, 1'b1);
            chk("R7 go with flow control off", tx_go, 1'b1);
        end
        tx_start_req = 1'b0;
        step();
        chk("R8 off mode no request", tx_go, 1'b0);

        finish_run();
    end
endmodule